// File: doc/BRIEF.md
# Subroutine Exit and Register-Restore Sequencer

This block carries out a subroutine EXIT in hardware. It sits between the register file and the data cache. When an EXIT is accepted, it reads the saved return address from slot 0 of the stack frame and hands that address to fetch with a one-cycle valid pulse, so fetch can redirect while the rest of the sequence is still running. It then reloads a contiguous range of preserved registers, one per cycle and in ascending order, from the slots that follow. As its last step it releases the frame: it writes the new stack pointer and, in the same cycle, tells the cache that the bytes just popped can be dropped without writeback.

After a release, the block holds the register range and frame base of that EXIT for a short window. A closely following ENTER that would save exactly the same registers to exactly the same frame slots does not need to store them, because memory already holds those values. The sequencer reports each accepted ENTER either as a skipped save or as a normal save, for the store logic outside the block to act on.

Top module: `exit_restore_seq`

## Requirements
- R1: After reset, busy, mem_rd_valid, ret_valid, rf_we, sp_we, discard_valid, enter_skip and enter_save are all low.
- R2: An EXIT presented while busy is low is accepted at that clock edge. From the next cycle busy stays high for exactly n+3 cycles, where n = last-first+1 when first <= last and n = 0 otherwise.
- R3: The first memory read of an EXIT is at the frame base. One cycle later ret_valid pulses exactly once, with ret_addr equal to the low address-width bits of the returned data. This happens while busy is high and before any register write.
- R4: Register r (first <= r <= last) is written in ascending order, one per consecutive cycle, with the data read from frame base + 8*(r-first+1). Memory read data arrives one cycle after the request.
- R5: When first > last, no register is written, and the frame released is a single 8-byte slot.
- R6: Frame release is the last busy cycle, after the return address and every register write. sp_we pulses with frame base + 8*(n+1). In the same cycle discard_valid pulses with discard_base equal to the frame base and discard_len equal to 8*(n+1).
- R7: An ENTER presented while busy is high, or in the same cycle as an EXIT, is not accepted until busy is low. Until then neither enter_skip nor enter_save pulses.
- R8: An ENTER accepted in any of the first 8 idle cycles after a release, with first, last and frame base all equal to that EXIT's, yields one enter_skip pulse in the cycle after acceptance.
- R9: An ENTER accepted later than that window, or with any field differing, yields one enter_save pulse in the cycle after acceptance. Any accepted ENTER or EXIT closes the window, so a second matching ENTER gets enter_save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exit_req | input | 1 | EXIT request, held until accepted |
| exit_first | input | RW | Lowest preserved register to reload |
| exit_last | input | RW | Highest preserved register to reload |
| exit_fp | input | AW | Frame base address (return address slot) |
| enter_req | input | 1 | ENTER request, held until accepted |
| enter_first | input | RW | Lowest register the ENTER would save |
| enter_last | input | RW | Highest register the ENTER would save |
| enter_fp | input | AW | Frame base the ENTER would save into |
| busy | output | 1 | Sequence in progress; new requests stall |
| mem_rd_valid | output | 1 | Read request to the data cache |
| mem_rd_addr | output | AW | Read byte address |
| mem_rd_data | input | DW | Read data, one cycle after the request |
| ret_valid | output | 1 | Return address valid pulse |
| ret_addr | output | AW | Loaded return address |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | RW | Register file write index |
| rf_wdata | output | DW | Register file write data |
| sp_we | output | 1 | Stack pointer write pulse |
| sp_wdata | output | AW | New stack pointer value |
| discard_valid | output | 1 | Popped-frame discard hint pulse |
| discard_base | output | AW | Start of popped range |
| discard_len | output | AW | Byte length of popped range |
| enter_skip | output | 1 | Accepted ENTER's save is suppressed |
| enter_save | output | 1 | Accepted ENTER must save normally |

## Verification
The assertions assume that the cache answers every read exactly one cycle after the request, and that a requester keeps its request and fields steady until the request is accepted. They also assume that a frame base plus its slots does not wrap the address space. In the bench, the memory model is a register clocked by the read request. Requests are driven on falling edges and dropped only after busy has been seen low at an accepting edge. Frame bases are chosen well below the top of the address range.

// File: rtl/exr_pkg.sv
package exr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_LD_RA   = 3'd1,
      ST_LD_REG  = 3'd2,
      ST_DRAIN   = 3'd3,
      ST_RELEASE = 3'd4
   } exr_state_e;
endpackage

// File: rtl/exr_addr_gen.sv
module exr_addr_gen #(
   parameter int AW         = 32,
   parameter int RW         = 5,
   parameter int SLOT_BYTES = 8
) (
   input  logic [AW-1:0] frame_base,
   input  logic [RW-1:0] reg_lo,
   input  logic [RW-1:0] reg_hi,
   input  logic [RW-1:0] reg_cur,
   input  logic          pick_ra,
   output logic [AW-1:0] slot_addr,
   output logic [AW-1:0] pop_len,
   output logic [AW-1:0] new_sp,
   output logic          span_empty
);
   localparam int SH = $clog2(SLOT_BYTES);
   localparam logic [AW-1:0] SLOT_W = AW'(SLOT_BYTES);

   if (AW <= RW + 1) begin : g_bad_aw
      $error("exr_addr_gen: AW must exceed RW+1");
   end

   logic [RW:0]   ord_n;
   logic [RW:0]   cnt_n;
   logic [AW-1:0] ord_w;
   logic [AW-1:0] cnt_w;
   logic [AW-1:0] ord_off;
   logic [AW-1:0] cnt_off;

   assign span_empty = reg_lo > reg_hi;
   assign ord_n      = pick_ra ? '0 : ({1'b0, reg_cur} - {1'b0, reg_lo} + 1'b1);
   assign cnt_n      = span_empty ? (RW+1)'(1) : ({1'b0, reg_hi} - {1'b0, reg_lo} + (RW+1)'(2));
   assign ord_w      = {{(AW-RW-1){1'b0}}, ord_n};
   assign cnt_w      = {{(AW-RW-1){1'b0}}, cnt_n};

   if ((1 << SH) == SLOT_BYTES) begin : g_shift
      assign ord_off = ord_w << SH;
      assign cnt_off = cnt_w << SH;
   end else begin : g_mult
      assign ord_off = ord_w * SLOT_W;
      assign cnt_off = cnt_w * SLOT_W;
   end

   assign slot_addr = frame_base + ord_off;
   assign pop_len   = cnt_off;
   assign new_sp    = frame_base + cnt_off;
endmodule

// File: rtl/exr_fsm.sv
module exr_fsm
   import exr_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 64,
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          exit_acc,
   input  logic [RW-1:0] exit_first,
   input  logic [RW-1:0] exit_last,
   input  logic [AW-1:0] exit_fp,
   input  logic [DW-1:0] mem_rd_data,
   input  logic [AW-1:0] slot_addr,
   input  logic          span_empty,
   output logic          busy,
   output logic          pick_ra,
   output logic [RW-1:0] cur_first,
   output logic [RW-1:0] cur_last,
   output logic [AW-1:0] cur_fp,
   output logic [RW-1:0] cur_idx,
   output logic          mem_rd_valid,
   output logic [AW-1:0] mem_rd_addr,
   output logic          ret_valid,
   output logic [AW-1:0] ret_addr,
   output logic          rf_we,
   output logic [RW-1:0] rf_waddr,
   output logic [DW-1:0] rf_wdata,
   output logic          release_now
);
   exr_state_e    state_q;
   logic [RW-1:0] first_q, last_q, idx_q;
   logic [AW-1:0] fp_q;
   logic          pend_v_q, pend_ra_q;
   logic [RW-1:0] pend_reg_q;
   logic          ra_seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         first_q    <= '0;
         last_q     <= '0;
         idx_q      <= '0;
         fp_q       <= '0;
         pend_v_q   <= 1'b0;
         pend_ra_q  <= 1'b0;
         pend_reg_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               pend_v_q <= 1'b0;
               if (exit_acc) begin
                  first_q <= exit_first;
                  last_q  <= exit_last;
                  idx_q   <= exit_first;
                  fp_q    <= exit_fp;
                  state_q <= ST_LD_RA;
               end
            end
            ST_LD_RA: begin
               pend_v_q  <= 1'b1;
               pend_ra_q <= 1'b1;
               state_q   <= span_empty ? ST_DRAIN : ST_LD_REG;
            end
            ST_LD_REG: begin
               pend_v_q   <= 1'b1;
               pend_ra_q  <= 1'b0;
               pend_reg_q <= idx_q;
               if (idx_q == last_q) state_q <= ST_DRAIN;
               else                 idx_q   <= idx_q + 1'b1;
            end
            ST_DRAIN: begin
               pend_v_q <= 1'b0;
               state_q  <= ST_RELEASE;
            end
            default: begin
               pend_v_q <= 1'b0;
               state_q  <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy         = state_q != ST_IDLE;
   assign pick_ra      = state_q == ST_LD_RA;
   assign cur_first    = first_q;
   assign cur_last     = last_q;
   assign cur_fp       = fp_q;
   assign cur_idx      = idx_q;
   assign mem_rd_valid = (state_q == ST_LD_RA) || (state_q == ST_LD_REG);
   assign mem_rd_addr  = slot_addr;
   assign ret_valid    = pend_v_q && pend_ra_q;
   assign ret_addr     = mem_rd_data[AW-1:0];
   assign rf_we        = pend_v_q && !pend_ra_q;
   assign rf_waddr     = pend_reg_q;
   assign rf_wdata     = mem_rd_data;
   assign release_now  = state_q == ST_RELEASE;

   // tracks whether the return address has gone out in the current sequence
   always_ff @(posedge clk) begin
      if (!rst_n)          ra_seen_q <= 1'b0;
      else if (!busy)      ra_seen_q <= 1'b0;
      else if (ret_valid)  ra_seen_q <= 1'b1;
   end

   // R3
   ra_before_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> ra_seen_q);
   // R3
   ra_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> busy);
   // R4
   reg_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && $past(rf_we)) |-> (rf_waddr == $past(rf_waddr) + 1'b1));
   // R6
   release_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_now |-> (!mem_rd_valid && !rf_we && !ret_valid));
   // R6
   release_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_now |=> !busy);
   // R2
   start_reads_ra_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (mem_rd_valid && mem_rd_addr == fp_q));
endmodule

// File: rtl/exr_shortcut.sv
module exr_shortcut #(
   parameter int AW  = 32,
   parameter int RW  = 5,
   parameter int WIN = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic [RW-1:0] arm_first,
   input  logic [RW-1:0] arm_last,
   input  logic [AW-1:0] arm_fp,
   input  logic          exit_acc,
   input  logic          enter_acc,
   input  logic [RW-1:0] enter_first,
   input  logic [RW-1:0] enter_last,
   input  logic [AW-1:0] enter_fp,
   output logic          enter_skip,
   output logic          enter_save
);
   localparam int CW = $clog2(WIN + 1);
   localparam logic [CW-1:0] WIN_W = CW'(WIN);

   if (WIN < 1) begin : g_bad_win
      $error("exr_shortcut: WIN must be at least 1");
   end

   logic [CW-1:0] win_q;
   logic [RW-1:0] key_first_q, key_last_q;
   logic [AW-1:0] key_fp_q;
   logic          hit;
   logic          skip_q, save_q;

   assign hit = (win_q != '0) && (enter_first == key_first_q) &&
                (enter_last == key_last_q) && (enter_fp == key_fp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q       <= '0;
         key_first_q <= '0;
         key_last_q  <= '0;
         key_fp_q    <= '0;
         skip_q      <= 1'b0;
         save_q      <= 1'b0;
      end else begin
         skip_q <= enter_acc && hit;
         save_q <= enter_acc && !hit;
         if (arm) begin
            win_q       <= WIN_W;
            key_first_q <= arm_first;
            key_last_q  <= arm_last;
            key_fp_q    <= arm_fp;
         end else if (exit_acc || enter_acc) begin
            win_q <= '0;
         end else if (win_q != '0) begin
            win_q <= win_q - 1'b1;
         end
      end
   end

   assign enter_skip = skip_q;
   assign enter_save = save_q;

   // R8
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({enter_skip, enter_save}));
   // R9
   window_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_acc && !arm) |=> (win_q == '0));
   // R8
   verdict_follows_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_skip || enter_save) |-> $past(enter_acc));
endmodule

// File: rtl/exit_restore_seq.sv
module exit_restore_seq #(
   parameter int AW         = 32,
   parameter int DW         = 64,
   parameter int RW         = 5,
   parameter int SLOT_BYTES = 8,
   parameter int WIN        = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          exit_req,
   input  logic [RW-1:0] exit_first,
   input  logic [RW-1:0] exit_last,
   input  logic [AW-1:0] exit_fp,
   input  logic          enter_req,
   input  logic [RW-1:0] enter_first,
   input  logic [RW-1:0] enter_last,
   input  logic [AW-1:0] enter_fp,
   output logic          busy,
   output logic          mem_rd_valid,
   output logic [AW-1:0] mem_rd_addr,
   input  logic [DW-1:0] mem_rd_data,
   output logic          ret_valid,
   output logic [AW-1:0] ret_addr,
   output logic          rf_we,
   output logic [RW-1:0] rf_waddr,
   output logic [DW-1:0] rf_wdata,
   output logic          sp_we,
   output logic [AW-1:0] sp_wdata,
   output logic          discard_valid,
   output logic [AW-1:0] discard_base,
   output logic [AW-1:0] discard_len,
   output logic          enter_skip,
   output logic          enter_save
);
   if (DW < AW) begin : g_bad_dw
      $error("exit_restore_seq: DW must hold a return address");
   end

   logic          exit_acc, enter_acc;
   logic          pick_ra, span_empty, release_now;
   logic [RW-1:0] cur_first, cur_last, cur_idx;
   logic [AW-1:0] cur_fp, slot_addr, pop_len, new_sp;

   assign exit_acc  = exit_req && !busy;
   assign enter_acc = enter_req && !busy && !exit_req;

   exr_addr_gen #(.AW(AW), .RW(RW), .SLOT_BYTES(SLOT_BYTES)) u_addr (
      .frame_base (cur_fp),
      .reg_lo     (cur_first),
      .reg_hi     (cur_last),
      .reg_cur    (cur_idx),
      .pick_ra    (pick_ra),
      .slot_addr  (slot_addr),
      .pop_len    (pop_len),
      .new_sp     (new_sp),
      .span_empty (span_empty)
   );

   exr_fsm #(.AW(AW), .DW(DW), .RW(RW)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .exit_acc     (exit_acc),
      .exit_first   (exit_first),
      .exit_last    (exit_last),
      .exit_fp      (exit_fp),
      .mem_rd_data  (mem_rd_data),
      .slot_addr    (slot_addr),
      .span_empty   (span_empty),
      .busy         (busy),
      .pick_ra      (pick_ra),
      .cur_first    (cur_first),
      .cur_last     (cur_last),
      .cur_fp       (cur_fp),
      .cur_idx      (cur_idx),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_addr  (mem_rd_addr),
      .ret_valid    (ret_valid),
      .ret_addr     (ret_addr),
      .rf_we        (rf_we),
      .rf_waddr     (rf_waddr),
      .rf_wdata     (rf_wdata),
      .release_now  (release_now)
   );

   exr_shortcut #(.AW(AW), .RW(RW), .WIN(WIN)) u_short (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm         (release_now),
      .arm_first   (cur_first),
      .arm_last    (cur_last),
      .arm_fp      (cur_fp),
      .exit_acc    (exit_acc),
      .enter_acc   (enter_acc),
      .enter_first (enter_first),
      .enter_last  (enter_last),
      .enter_fp    (enter_fp),
      .enter_skip  (enter_skip),
      .enter_save  (enter_save)
   );

   assign sp_we         = release_now;
   assign sp_wdata      = new_sp;
   assign discard_valid = release_now;
   assign discard_base  = cur_fp;
   assign discard_len   = pop_len;

   // R7
   no_verdict_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> !(enter_skip || enter_save));
   // R6
   hint_with_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      discard_valid |-> (sp_we && sp_wdata == discard_base + discard_len));
endmodule

// File: tb/sim_exit_restore_seq.sv
module sim_exit_restore_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exit_req = 1'b0, enter_req = 1'b0;
   logic [4:0]  exit_first = '0, exit_last = '0, enter_first = '0, enter_last = '0;
   logic [31:0] exit_fp = '0, enter_fp = '0;
   logic        busy, mem_rd_valid, ret_valid, rf_we, sp_we, discard_valid;
   logic        enter_skip, enter_save;
   logic [31:0] mem_rd_addr, ret_addr, sp_wdata, discard_base, discard_len;
   logic [63:0] mem_rd_data = '0, rf_wdata;
   logic [4:0]  rf_waddr;

   int tests = 0, fails = 0;
   int cyc = 0;
   int busy_cnt, ret_cnt, ret_cyc, rf_cnt, sp_cnt, sp_cyc, disc_cnt, disc_cyc, skip_cnt, save_cnt;
   logic        ret_busy;
   logic [31:0] ret_val, sp_val, disc_b, disc_l;
   logic [4:0]  rf_a [32];
   logic [63:0] rf_d [32];
   int          rf_c [32];

   always #5 clk = ~clk;

   exit_restore_seq u0 (.*);

   function automatic logic [63:0] mdata(logic [31:0] a);
      return {a ^ 32'h5A5A0000, ~a};
   endfunction

   always @(posedge clk) if (mem_rd_valid) mem_rd_data <= mdata(mem_rd_addr);

   always @(negedge clk) begin
      cyc++;
      if (busy) busy_cnt++;
      if (ret_valid) begin ret_cnt++; ret_cyc = cyc; ret_val = ret_addr; ret_busy = busy; end
      if (rf_we && rf_cnt < 32) begin
         rf_a[rf_cnt] = rf_waddr; rf_d[rf_cnt] = rf_wdata; rf_c[rf_cnt] = cyc; rf_cnt++;
      end
      if (sp_we) begin sp_cnt++; sp_cyc = cyc; sp_val = sp_wdata; end
      if (discard_valid) begin disc_cnt++; disc_cyc = cyc; disc_b = discard_base; disc_l = discard_len; end
      if (enter_skip) skip_cnt++;
      if (enter_save) save_cnt++;
   end

   task automatic clr_mon();
      busy_cnt = 0; ret_cnt = 0; ret_cyc = 0; rf_cnt = 0; sp_cnt = 0; sp_cyc = 0;
      disc_cnt = 0; disc_cyc = 0; skip_cnt = 0; save_cnt = 0; ret_busy = 1'b0;
   endtask

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // drive one EXIT at idle and wait for the sequence to finish
   task automatic run_exit(logic [4:0] f, logic [4:0] l, logic [31:0] fp);
      @(negedge clk);
      clr_mon();
      exit_req = 1'b1; exit_first = f; exit_last = l; exit_fp = fp;
      @(negedge clk);
      exit_req = 1'b0;
      while (busy) @(negedge clk);
   endtask

   task automatic check_exit(logic [4:0] f, logic [4:0] l, logic [31:0] fp);
      int n;
      n = (f <= l) ? (int'(l) - int'(f) + 1) : 0;
      // R2
      chk(busy_cnt == n + 3, "R2", "busy cycles", busy_cnt, n + 3);
      // R3
      chk(ret_cnt == 1 && ret_val == ~fp && ret_busy, "R3", "return address", ret_val, ~fp);
      if (n > 0) chk(ret_cyc < rf_c[0], "R3", "ret before reg", ret_cyc, rf_c[0]);
      // R4 / R5
      chk(rf_cnt == n, (n == 0) ? "R5" : "R4", "reg write count", rf_cnt, n);
      for (int i = 0; i < n && i < rf_cnt; i++) begin
         chk(rf_a[i] == f + 5'(i), "R4", "reg index", rf_a[i], f + 5'(i));
         chk(rf_d[i] == mdata(fp + 32'(8 * (i + 1))), "R4", "reg data", rf_d[i], mdata(fp + 32'(8 * (i + 1))));
         if (i > 0) chk(rf_c[i] == rf_c[i-1] + 1, "R4", "one per cycle", rf_c[i], rf_c[i-1] + 1);
      end
      // R6
      chk(sp_cnt == 1 && sp_val == fp + 32'(8 * (n + 1)), (n == 0) ? "R5" : "R6", "new sp", sp_val, fp + 32'(8 * (n + 1)));
      chk(sp_cyc > ret_cyc && (n == 0 || sp_cyc > rf_c[n-1]), "R6", "release last", sp_cyc, ret_cyc);
      chk(disc_cnt == 1 && disc_cyc == sp_cyc && disc_b == fp && disc_l == 32'(8 * (n + 1)),
          "R6", "discard hint", disc_l, 8 * (n + 1));
   endtask

   // present ENTER after `waits` further idle cycles; expect skip (1) or save (0)
   task automatic run_enter(int waits, logic [4:0] f, logic [4:0] l, logic [31:0] fp, bit exp_skip, string req);
      repeat (waits) @(negedge clk);
      skip_cnt = 0; save_cnt = 0;
      enter_req = 1'b1; enter_first = f; enter_last = l; enter_fp = fp;
      @(negedge clk);
      enter_req = 1'b0;
      @(negedge clk);
      chk(skip_cnt == int'(exp_skip) && save_cnt == int'(!exp_skip), req, "enter verdict skip", skip_cnt, int'(exp_skip));
   endtask

   task automatic t_reset();
      // R1
      chk(!busy && !mem_rd_valid && !ret_valid && !rf_we && !sp_we && !discard_valid && !enter_skip && !enter_save,
          "R1", "idle after reset", busy, 0);
   endtask

   task automatic t_exits();
      run_exit(5'd3, 5'd6, 32'h0000_1000); check_exit(5'd3, 5'd6, 32'h0000_1000);
      run_exit(5'd9, 5'd9, 32'h0000_2040); check_exit(5'd9, 5'd9, 32'h0000_2040);
      run_exit(5'd7, 5'd3, 32'h0000_3000); check_exit(5'd7, 5'd3, 32'h0000_3000);
      run_exit(5'd0, 5'd31, 32'h0001_0000); check_exit(5'd0, 5'd31, 32'h0001_0000);
   endtask

   task automatic t_window();
      run_exit(5'd2, 5'd4, 32'h0000_4000);
      run_enter(0, 5'd2, 5'd4, 32'h0000_4000, 1'b1, "R8");
      run_enter(0, 5'd2, 5'd4, 32'h0000_4000, 1'b0, "R9");
      run_exit(5'd2, 5'd4, 32'h0000_4000);
      run_enter(7, 5'd2, 5'd4, 32'h0000_4000, 1'b1, "R8");
      run_exit(5'd2, 5'd4, 32'h0000_4000);
      run_enter(8, 5'd2, 5'd4, 32'h0000_4000, 1'b0, "R9");
      run_exit(5'd2, 5'd4, 32'h0000_4000);
      run_enter(0, 5'd2, 5'd4, 32'h0000_4008, 1'b0, "R9");
      run_exit(5'd2, 5'd4, 32'h0000_4000);
      run_enter(0, 5'd2, 5'd5, 32'h0000_4000, 1'b0, "R9");
      run_exit(5'd2, 5'd4, 32'h0000_4000);
      run_enter(0, 5'd1, 5'd4, 32'h0000_4000, 1'b0, "R9");
   endtask

   // ENTER raised during an EXIT (same_cycle=1: in the EXIT's own cycle)
   task automatic t_stall(bit same_cycle);
      int early;
      @(negedge clk);
      clr_mon();
      exit_req = 1'b1; exit_first = 5'd10; exit_last = 5'd12; exit_fp = 32'h0000_5000;
      enter_first = 5'd10; enter_last = 5'd12; enter_fp = 32'h0000_5000;
      if (same_cycle) enter_req = 1'b1;
      @(negedge clk);
      exit_req = 1'b0; enter_req = 1'b1;
      while (busy) @(negedge clk);
      early = skip_cnt + save_cnt;
      // R7
      chk(early == 0, "R7", "no verdict while busy", early, 0);
      chk(ret_cnt == 1 && rf_cnt == 3, "R7", "exit ran first", rf_cnt, 3);
      @(negedge clk);
      enter_req = 1'b0;
      @(negedge clk);
      chk(skip_cnt == 1 && save_cnt == 0, "R7", "stalled enter hits window", skip_cnt, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      clr_mon();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_exits();
      t_window();
      t_stall(1'b0);
      repeat (12) @(negedge clk);
      t_stall(1'b1);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule